// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Per-Entry Page Size

This block is a unified address translation buffer with 64 fully associative entries. Instruction and data lookups share it. Hardware never fills or evicts entries. Software loads every entry, one 32-bit word at a time, through a write port. It can read any word back through a read port.

Each entry holds two words: a tag word and a data word. A search takes an effective address and compares it with all valid entries at once. It returns a hit flag, the index of the matching entry, the translated physical address, the permission bits, the zone field and the storage attributes.

Every entry carries its own 3-bit page-size code. That code sets how many effective-address bits take part in the compare. Pages of 1 KB through 16 MB can therefore coexist in the buffer.

Top module: `vps_tlb`

## Requirements
- R1: The buffer holds 64 entries, selected by a 6-bit index. A write (`wr_en` high) stores `wr_word` into the tag word when `wr_sel`=0 and into the data word when `wr_sel`=1. While reset is low, `rd_word` shows the word chosen by `rd_idx` and `rd_sel` with the same encoding, without delay.
- R2: Synchronous reset clears every word of every entry, including all valid bits. `rd_word` reads zero while `rst` is high. All search outputs are zero after reset.
- R3: The tag word is laid out as follows: effective page number in bits [31:10], page-size code in bits [9:7], valid flag at bit 6. An entry whose valid flag is 0 never hits.
- R4: Page-size code k (0..7) selects a page of 2^(10+2k) bytes, from 1K up to 16M. The compare uses only effective-address bits [31:10+2k] against the same bits of the stored page number.
- R5: The data word is laid out as follows: real page number in bits [31:10], execute permission at bit 9, write permission at bit 8, a 4-bit zone in bits [7:4], and attributes in bits [3:0]. The attributes are write-through at bit 3, inhibit at bit 2, coherent at bit 1 and guarded at bit 0. On a hit these fields appear unchanged on the outputs.
- R6: On a hit, the physical address takes the real page number bits above the page offset. The bits below bit 10+2k come from the searched address.
- R7: When several valid entries match, the lowest index is reported, together with that entry's translation.
- R8: A search request in one cycle gives its results on the outputs after the next clock edge. `srch_done` is high for exactly one cycle. The results hold until the next request.
- R9: A write takes effect at its clock edge. A search requested in the following cycle sees the new contents.
- R10: On a miss, the hit flag, the index, the physical address, the permission bits, the zone and the attributes are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry word |
| wr_idx | input | 6 | Entry written |
| wr_sel | input | 1 | 0 = tag word, 1 = data word |
| wr_word | input | 32 | Word to store |
| rd_idx | input | 6 | Entry read |
| rd_sel | input | 1 | 0 = tag word, 1 = data word |
| rd_word | output | 32 | Word read (zero during reset) |
| srch_req | input | 1 | Start a search |
| srch_ea | input | 32 | Effective address searched |
| srch_done | output | 1 | Search result valid this cycle |
| srch_hit | output | 1 | A valid entry matched |
| srch_idx | output | 6 | Lowest matching index |
| srch_pa | output | 32 | Translated physical address |
| srch_exec | output | 1 | Execute permission of the match |
| srch_write | output | 1 | Write permission of the match |
| srch_zone | output | 4 | Zone field of the match |
| srch_attr | output | 4 | Storage attributes of the match |

## Verification
The assertions assume two things about the inputs. First, `srch_ea` is held steady through the cycle in which `srch_req` is sampled. Second, reset lasts at least one clock edge before requests begin. The low-offset check relies on that stable address to compare the result with the address captured one cycle earlier. The bench changes inputs only on the falling edge, starts with reset high, and issues each request for a single cycle with a fixed address. Write-after-search ordering is exercised only in the order that R9 defines: the write edge comes first, then the request.

// File: rtl/vps_tlb_pkg.sv
package vps_tlb_pkg;

    localparam int WORD_W = 32;
    localparam int PN_LSB = 10;
    localparam int PN_W   = WORD_W - PN_LSB;
    localparam int SZ_W   = 3;

    typedef struct packed {
        logic [PN_W-1:0] epn;
        logic [SZ_W-1:0] psize;
        logic            valid;
        logic [5:0]      spare;
    } tag_word_t;

    typedef struct packed {
        logic [PN_W-1:0] rpn;
        logic            x_ok;
        logic            w_ok;
        logic [3:0]      zone;
        logic [3:0]      attr;
    } data_word_t;

    // Page-number bits that take part in the compare for a size code
    function automatic logic [PN_W-1:0] pn_keep(input logic [SZ_W-1:0] sz);
        logic [PN_W-1:0] ones;
        ones = '1;
        return ones << {sz, 1'b0};
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import vps_tlb_pkg::*;
#(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic                  wr_sel,
    input  logic [WORD_W-1:0]     wr_word,
    input  logic [IW-1:0]         rd_idx,
    input  logic                  rd_sel,
    output logic [WORD_W-1:0]     rd_word,
    output tag_word_t  [N-1:0]    tags,
    output data_word_t [N-1:0]    datas
);

    for (genvar e = 0; e < N; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tags[e]  <= '0;
                datas[e] <= '0;
            end else if (wr_en && wr_idx == IW'(e)) begin
                if (wr_sel) datas[e] <= data_word_t'(wr_word);
                else        tags[e]  <= tag_word_t'(wr_word);
            end
        end
    end

    always_comb begin
        if (rst)         rd_word = '0;
        else if (rd_sel) rd_word = datas[rd_idx];
        else             rd_word = tags[rd_idx];
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import vps_tlb_pkg::*;
#(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  tag_word_t [N-1:0]  tags,
    input  logic [WORD_W-1:0]  ea,
    output logic               hit,
    output logic [IW-1:0]      idx
);

    logic [N-1:0] eq;

    for (genvar e = 0; e < N; e++) begin : g_cmp
        logic [PN_W-1:0] keep;
        assign keep  = pn_keep(tags[e].psize);
        assign eq[e] = tags[e].valid &&
                       (((ea[WORD_W-1:PN_LSB] ^ tags[e].epn) & keep) == '0);
    end

    // Lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import vps_tlb_pkg::*;
(
    input  logic [SZ_W-1:0]   psize,
    input  data_word_t        dw,
    input  logic [WORD_W-1:0] ea,
    output logic [WORD_W-1:0] pa
);

    logic [PN_W-1:0] keep;

    always_comb begin
        keep = pn_keep(psize);
        pa   = {(dw.rpn & keep) | (ea[WORD_W-1:PN_LSB] & ~keep),
                ea[PN_LSB-1:0]};
    end

endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
    import vps_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IW = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic              wr_sel,
    input  logic [31:0]       wr_word,
    input  logic [IW-1:0]     rd_idx,
    input  logic              rd_sel,
    output logic [31:0]       rd_word,
    input  logic              srch_req,
    input  logic [31:0]       srch_ea,
    output logic              srch_done,
    output logic              srch_hit,
    output logic [IW-1:0]     srch_idx,
    output logic [31:0]       srch_pa,
    output logic              srch_exec,
    output logic              srch_write,
    output logic [3:0]        srch_zone,
    output logic [3:0]        srch_attr
);

    tag_word_t  [N_ENTRIES-1:0] tags;
    data_word_t [N_ENTRIES-1:0] datas;
    logic                       m_hit;
    logic [IW-1:0]              m_idx;
    logic [WORD_W-1:0]          m_pa;
    data_word_t                 m_dw;

    tlb_store #(.N(N_ENTRIES), .IW(IW)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_word(wr_word),
        .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_word(rd_word),
        .tags(tags), .datas(datas)
    );

    tlb_match #(.N(N_ENTRIES), .IW(IW)) u_match (
        .tags(tags), .ea(srch_ea), .hit(m_hit), .idx(m_idx)
    );

    assign m_dw = datas[m_idx];

    tlb_xlate u_xlate (
        .psize(tags[m_idx].psize), .dw(m_dw), .ea(srch_ea), .pa(m_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            srch_done  <= 1'b0;
            srch_hit   <= 1'b0;
            srch_idx   <= '0;
            srch_pa    <= '0;
            srch_exec  <= 1'b0;
            srch_write <= 1'b0;
            srch_zone  <= '0;
            srch_attr  <= '0;
        end else begin
            srch_done <= srch_req;
            if (srch_req) begin
                srch_hit   <= m_hit;
                srch_idx   <= m_hit ? m_idx : '0;
                srch_pa    <= m_hit ? m_pa : '0;
                srch_exec  <= m_hit & m_dw.x_ok;
                srch_write <= m_hit & m_dw.w_ok;
                srch_zone  <= m_hit ? m_dw.zone : '0;
                srch_attr  <= m_hit ? m_dw.attr : '0;
            end
        end
    end

endmodule

// File: rtl/vps_tlb_chk.sv
module vps_tlb_chk #(
    parameter int IW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          srch_req,
    input logic [31:0]   srch_ea,
    input logic          srch_done,
    input logic          srch_hit,
    input logic [IW-1:0] srch_idx,
    input logic [31:0]   srch_pa,
    input logic [31:0]   rd_word
);

    p_rd_zero_r2: assert property (@(posedge clk) rst |-> rd_word == '0);

    p_done_after_req_r8: assert property (@(posedge clk) disable iff (rst)
        srch_req |=> srch_done);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        !srch_req |=> !srch_done);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !srch_req |=> ($stable(srch_idx) && $stable(srch_pa) && $stable(srch_hit)));

    p_offset_r6: assert property (@(posedge clk) disable iff (rst)
        (srch_done && srch_hit) |-> srch_pa[9:0] == $past(srch_ea[9:0]));

    p_miss_clean_r10: assert property (@(posedge clk) disable iff (rst)
        (srch_done && !srch_hit) |-> (srch_idx == '0 && srch_pa == '0));

endmodule

bind vps_tlb vps_tlb_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst(rst), .srch_req(srch_req), .srch_ea(srch_ea),
    .srch_done(srch_done), .srch_hit(srch_hit), .srch_idx(srch_idx),
    .srch_pa(srch_pa), .rd_word(rd_word)
);

// File: tb/vps_tlb_test.sv
module vps_tlb_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_word = '0;
    logic [5:0]  rd_idx = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_word;
    logic        srch_req = 1'b0;
    logic [31:0] srch_ea = '0;
    logic        srch_done, srch_hit, srch_exec, srch_write;
    logic [5:0]  srch_idx;
    logic [31:0] srch_pa;
    logic [3:0]  srch_zone, srch_attr;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    vps_tlb uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_word(wr_word),
        .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_word(rd_word),
        .srch_req(srch_req), .srch_ea(srch_ea),
        .srch_done(srch_done), .srch_hit(srch_hit), .srch_idx(srch_idx),
        .srch_pa(srch_pa), .srch_exec(srch_exec), .srch_write(srch_write),
        .srch_zone(srch_zone), .srch_attr(srch_attr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic sel, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_sel = sel; wr_word = w;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Request in one cycle, results sampled on the falling edge after the capture edge
    task automatic lookup(input logic [31:0] ea);
        srch_req = 1'b1; srch_ea = ea;
        @(posedge clk);
        @(negedge clk);
        srch_req = 1'b0;
    endtask

    task automatic expect_hit(input string req, input int idx, input logic [31:0] pa,
                              input logic x, input logic w,
                              input logic [3:0] z, input logic [3:0] a);
        check(req, {31'd0, srch_done}, 32'd1);
        check(req, {31'd0, srch_hit}, 32'd1);
        check(req, {26'd0, srch_idx}, 32'(idx));
        check(req, srch_pa, pa);
        check(req, {30'd0, srch_exec, srch_write}, {30'd0, x, w});
        check(req, {24'd0, srch_zone, srch_attr}, {24'd0, z, a});
    endtask

    task automatic expect_miss(input string req);
        check(req, {31'd0, srch_done}, 32'd1);
        check(req, {31'd0, srch_hit}, 32'd0);
        check(req, {26'd0, srch_idx}, 32'd0);
        check(req, srch_pa, 32'd0);
        check(req, {22'd0, srch_exec, srch_write, srch_zone, srch_attr}, 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        rd_idx = 6'd5; rd_sel = 1'b1;
        @(negedge clk);
        check("R2 read in reset", rd_word, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 data cleared", rd_word, 32'd0);
        rd_sel = 1'b0;
        #1 check("R2 tag cleared", rd_word, 32'd0);
        check("R2 outputs cleared", {srch_done, srch_hit, 30'd0}, 32'd0);
        check("R2 pa cleared", srch_pa, 32'd0);
    endtask

    task automatic t_readback;
        put(63, 1'b0, 32'hDEAD_BC00);   // valid bit 6 clear
        put(63, 1'b1, 32'h1234_5678);
        rd_idx = 6'd63; rd_sel = 1'b0;
        #1 check("R1 tag read", rd_word, 32'hDEAD_BC00);
        rd_sel = 1'b1;
        #1 check("R1 data read", rd_word, 32'h1234_5678);
        lookup(32'hDEAD_BC00);
        expect_miss("R3 invalid entry never hits");
    endtask

    task automatic t_page_4k;
        put(5, 1'b0, 32'h1234_5000 | (32'd1 << 7) | 32'h40);
        put(5, 1'b1, 32'hABCD_E000 | 32'h200 | 32'h30 | 32'h5);
        rd_idx = 6'd5; rd_sel = 1'b1;
        #1 check("R1 data 5 read", rd_word, 32'hABCD_E235);
        lookup(32'h1234_5ABC);
        expect_hit("R5 R6 4K hit", 5, 32'hABCD_EABC, 1'b1, 1'b0, 4'h3, 4'h5);
        lookup(32'h1234_4ABC);
        expect_miss("R4 4K bit12 differs");
        lookup(32'h1234_5400);
        expect_hit("R4 4K low bits ignored", 5, 32'hABCD_E400, 1'b1, 1'b0, 4'h3, 4'h5);
    endtask

    task automatic t_page_16m;
        put(9, 1'b0, 32'h5500_0000 | (32'd7 << 7) | 32'h40);
        put(9, 1'b1, 32'h7700_0000 | 32'h100 | 32'h8);
        lookup(32'h55AB_CDEF);
        expect_hit("R4 R6 16M hit", 9, 32'h77AB_CDEF, 1'b0, 1'b1, 4'h0, 4'h8);
        lookup(32'h54AB_CDEF);
        expect_miss("R4 16M bit24 differs");
    endtask

    task automatic t_page_1k;
        put(12, 1'b0, 32'h0000_0C40);
        put(12, 1'b1, 32'h0040_0000 | 32'h80 | 32'hF);
        lookup(32'h0000_0FFF);
        expect_hit("R4 1K hit", 12, 32'h0040_03FF, 1'b0, 1'b0, 4'h8, 4'hF);
        lookup(32'h0000_0800);
        expect_miss("R4 1K bit10 differs");
    endtask

    task automatic t_priority;
        put(40, 1'b0, 32'h3000_02C0);
        put(40, 1'b1, 32'h2220_0000);
        put(20, 1'b0, 32'h3000_02C0);
        put(20, 1'b1, 32'h1110_0000);
        lookup(32'h3001_2345);
        expect_hit("R7 lowest index", 20, 32'h1111_2345, 1'b0, 1'b0, 4'h0, 4'h0);
        // invalidate entry 20, search on the very next cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd20; wr_sel = 1'b0; wr_word = 32'h0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        lookup(32'h3001_2345);
        expect_hit("R9 R3 write seen next cycle", 40, 32'h2221_2345, 1'b0, 1'b0, 4'h0, 4'h0);
    endtask

    task automatic t_hold;
        lookup(32'h55AB_CDEF);
        srch_ea = 32'h0;
        @(negedge clk);
        check("R8 done one cycle", {31'd0, srch_done}, 32'd0);
        check("R8 result held", srch_pa, 32'h77AB_CDEF);
        check("R8 idx held", {26'd0, srch_idx}, 32'd9);
    endtask

    initial begin : main
        t_reset();
        t_readback();
        t_page_4k();
        t_page_16m();
        t_page_1k();
        t_priority();
        t_hold();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : watchdog
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule